// File: doc/BRIEF.md
# Power-of-Two Width Coordinator

This block sits between a producer of words of one width and a consumer that wants another width, where the two widths are related by a factor of two raised to a small exponent. Its most common use is between a capture memory, whose sample width equals the number of probed signals, and a system bus of fixed width. When the sample is wider than the bus, it is sent out as a run of narrower beats. When the sample is narrower, several samples are gathered into one bus word.

Three build-time parameters select the behaviour. `IN_W` is the input width, `POW` is the exponent of the ratio, and `DIR` is a signed direction. `DIR = 1` means the input is wider, so words are split, and `OUT_W = IN_W / 2^POW`. `DIR = -1` means the output is wider, so samples are packed, and `OUT_W = IN_W * 2^POW`. With `POW = 0` the block is a single pipeline register and `DIR` is irrelevant.

Both edges use a valid/ready handshake. A transfer happens on a rising clock edge at which both valid and ready are high. In packing mode a flush input closes a partly filled word early.

Top module: `wcoord_top`

## Requirements
- R1: With `POW = 0`, a word accepted at one clock edge appears on `out_data` with `out_valid` high after that edge. `in_ready` is high whenever the stage is empty or `out_ready` is high, which allows one word per cycle.
- R2: With `DIR = 1`, the output is `IN_W >> POW` bits wide and each accepted word produces exactly `2^POW` output beats. This holds for a factor of 4 and for a factor of 8.
- R3: When splitting, beat k carries bits `[k*OUT_W +: OUT_W]` of the accepted word. The least significant slice comes first, and the first beat is valid in the cycle after acceptance.
- R4: When splitting, `in_ready` is low from the cycle after a word is accepted until the last beat has been taken. It is high again in the cycle after that.
- R5: In every mode, while `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R6: When packing, the first accepted sample fills bits `[IN_W-1:0]` and sample k fills `[k*IN_W +: IN_W]`. `out_valid` rises only in the cycle after the `2^POW`-th sample is accepted, and `in_ready` is low while the packed word waits.
- R7: When packing, `in_flush` closes a partly filled word, and the unfilled upper slices read as zero. A sample accepted together with `in_flush` is included in the closed word. A flush with no sample pending and no sample offered produces no output.
- R8: In split and pass-through modes, `in_flush` has no effect on any output.
- R9: While `rst_n` is low, and in the cycle after its release, `out_valid` is low and `in_ready` is high.
- R10: `in_data` is sampled only at an edge where `in_valid` and `in_ready` are both high. Changes to `in_data` at other times do not reach the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Producer has a word on `in_data` |
| in_ready | output | 1 | Block can accept a word at the next edge |
| in_data | input | IN_W | Input word |
| in_flush | input | 1 | Packing mode only: close the partial word |
| out_valid | output | 1 | `out_data` holds a valid word |
| out_ready | input | 1 | Consumer takes the word at the next edge |
| out_data | output | OUT_W | Output word |

## Verification
The hardest state to reach from the ports is a stall in the middle of a split word: the beat counter is part-way through, `out_ready` drops, and a fresh input is already waiting on the input side. The stimulus holds `out_ready` low both on the first beat and again on an inner beat, and changes `in_data` while `in_valid` is low. It then confirms that the held slice, the slice order and the later word are all intact. The packing side is driven into a partial word and closed by flush in two ways, with and without a sample on the same edge. This is done right after an all-ones word, so that any stale bits in the padding would show.

// File: rtl/wcoord_pkg.sv
package wcoord_pkg;

  typedef enum logic [1:0] {
    WC_PASS  = 2'd0,
    WC_SPLIT = 2'd1,
    WC_PACK  = 2'd2
  } wc_mode_e;

  // Output width derived from input width, ratio exponent and direction.
  function automatic int unsigned wc_out_w(input int unsigned in_w,
                                           input int unsigned pow,
                                           input int          dir);
    if (pow == 0)     return in_w;
    else if (dir > 0) return in_w >> pow;
    else              return in_w << pow;
  endfunction

  function automatic wc_mode_e wc_mode(input int unsigned pow, input int dir);
    if (pow == 0)     return WC_PASS;
    else if (dir > 0) return WC_SPLIT;
    else              return WC_PACK;
  endfunction

endpackage

// File: rtl/wcoord_beat_cnt.sv
module wcoord_beat_cnt #(
  parameter  int unsigned BEATS = 4,
  localparam int unsigned CW    = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          clr,
  output logic [CW-1:0] idx,
  output logic          last
);

  logic [CW-1:0] idx_q;
  logic [CW-1:0] idx_d;
  logic          cnt_en;

  assign last   = (idx_q == CW'(BEATS - 1));
  assign cnt_en = adv | clr;

  always_comb begin
    idx_d = idx_q;
    if (clr || (adv && last)) begin
      idx_d = '0;
    end else if (adv) begin
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (cnt_en) begin
      idx_q <= idx_d;
    end
  end

  assign idx = idx_q;

endmodule

// File: rtl/wcoord_split.sv
module wcoord_split #(
  parameter  int unsigned IN_W  = 16,
  parameter  int unsigned POW   = 2,
  localparam int unsigned BEATS = 1 << POW,
  localparam int unsigned OUT_W = IN_W >> POW,
  localparam int unsigned CW    = (POW > 0) ? POW : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data
);

  logic            full_q;
  logic            full_d;
  logic [IN_W-1:0] shr_q;
  logic [IN_W-1:0] shr_d;
  logic            shr_en;
  logic            take;
  logic            give;
  logic            last_beat;
  logic [CW-1:0]   beat_idx_unused;

  assign in_ready = ~full_q;
  assign take     = in_valid & ~full_q;
  assign give     = full_q & out_ready;
  assign shr_en   = take | give;

  wcoord_beat_cnt #(.BEATS(BEATS)) u_beat (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (give),
    .clr  (1'b0),
    .idx  (beat_idx_unused),
    .last (last_beat)
  );

  always_comb begin
    full_d = full_q;
    shr_d  = shr_q;
    if (take) begin
      full_d = 1'b1;
      shr_d  = in_data;
    end else if (give) begin
      shr_d = shr_q >> OUT_W;
      if (last_beat) begin
        full_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else begin
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk) begin
    if (shr_en) begin
      shr_q <= shr_d;
    end
  end

  assign out_valid = full_q;
  assign out_data  = shr_q[OUT_W-1:0];

endmodule

// File: rtl/wcoord_pack.sv
module wcoord_pack #(
  parameter  int unsigned IN_W  = 4,
  parameter  int unsigned POW   = 2,
  localparam int unsigned BEATS = 1 << POW,
  localparam int unsigned OUT_W = IN_W << POW,
  localparam int unsigned CW    = (POW > 0) ? POW : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  input  logic             in_flush,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data
);

  logic          full_q;
  logic          full_d;
  logic          take;
  logic          give;
  logic          close;
  logic          last_beat;
  logic [CW-1:0] beat_idx;

  assign in_ready = ~full_q;
  assign take     = in_valid & ~full_q;
  assign give     = full_q & out_ready;
  // A word closes on its last slice, or early on flush if it holds anything.
  assign close    = (take & (last_beat | in_flush))
                  | (~full_q & in_flush & (beat_idx != '0));

  wcoord_beat_cnt #(.BEATS(BEATS)) u_beat (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (take),
    .clr  (close),
    .idx  (beat_idx),
    .last (last_beat)
  );

  for (genvar s = 0; s < BEATS; s++) begin : g_slot
    logic            slot_we;
    logic            slot_en;
    logic [IN_W-1:0] slot_d;
    logic [IN_W-1:0] slot_q;

    assign slot_we = take & (beat_idx == CW'(s));
    assign slot_en = slot_we | give;

    always_comb begin
      slot_d = slot_q;
      if (give) begin
        slot_d = '0;
      end else if (slot_we) begin
        slot_d = in_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (slot_en) begin
        slot_q <= slot_d;
      end
    end

    assign out_data[s*IN_W +: IN_W] = slot_q;
  end

  always_comb begin
    full_d = full_q;
    if (close) begin
      full_d = 1'b1;
    end else if (give) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else begin
      full_q <= full_d;
    end
  end

  assign out_valid = full_q;

endmodule

// File: rtl/wcoord_pass.sv
module wcoord_pass #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  logic         full_q;
  logic         full_d;
  logic         take;
  logic [W-1:0] data_q;

  assign in_ready = ~full_q | out_ready;
  assign take     = in_valid & in_ready;

  always_comb begin
    full_d = full_q;
    if (take) begin
      full_d = 1'b1;
    end else if (out_ready) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else begin
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      data_q <= in_data;
    end
  end

  assign out_valid = full_q;
  assign out_data  = data_q;

endmodule

// File: rtl/wcoord_top.sv
module wcoord_top
  import wcoord_pkg::*;
#(
  parameter  int unsigned IN_W  = 16,
  parameter  int unsigned POW   = 2,
  parameter  int          DIR   = 1,
  localparam int unsigned OUT_W = wc_out_w(IN_W, POW, DIR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  input  logic             in_flush,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data
);

  localparam wc_mode_e MODE = wc_mode(POW, DIR);

  if (MODE == WC_SPLIT) begin : g_split
    logic flush_unused;
    assign flush_unused = in_flush;

    wcoord_split #(.IN_W(IN_W), .POW(POW)) u_split (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .in_data  (in_data),
      .out_valid(out_valid),
      .out_ready(out_ready),
      .out_data (out_data)
    );
  end else if (MODE == WC_PACK) begin : g_pack
    wcoord_pack #(.IN_W(IN_W), .POW(POW)) u_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .in_data  (in_data),
      .in_flush (in_flush),
      .out_valid(out_valid),
      .out_ready(out_ready),
      .out_data (out_data)
    );
  end else begin : g_pass
    logic flush_unused;
    assign flush_unused = in_flush;

    wcoord_pass #(.W(IN_W)) u_pass (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .in_data  (in_data),
      .out_valid(out_valid),
      .out_ready(out_ready),
      .out_data (out_data)
    );
  end

endmodule

// File: rtl/wcoord_chk.sv
module wcoord_chk
  import wcoord_pkg::*;
#(
  parameter  int unsigned IN_W  = 16,
  parameter  int unsigned POW   = 2,
  parameter  int          DIR   = 1,
  localparam int unsigned OUT_W = wc_out_w(IN_W, POW, DIR)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [IN_W-1:0]  in_data,
  input logic             in_flush,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data
);

  localparam wc_mode_e MODE = wc_mode(POW, DIR);

  // R5: a stalled output word holds
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R10: no output appears without input or flush
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !in_valid && !in_flush) |=> !out_valid);

  if (MODE == WC_SPLIT) begin : g_split_chk
    // R4: accepting a word blocks the input side
    p_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_valid && !in_ready));
    // R3: first beat is the low slice of the accepted word
    p_first_slice_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_data == $past(in_data[OUT_W-1:0])));
  end else if (MODE == WC_PACK) begin : g_pack_chk
    // R6: a packed word appears only after an input or a flush
    p_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> ($past(in_valid && in_ready) || $past(in_flush)));
    // R6: the last sample of a full word lands in the top slice
    p_top_slice_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(out_valid) && !$past(in_flush))
        |-> (out_data[OUT_W-1 -: IN_W] == $past(in_data)));
  end else begin : g_pass_chk
    // R1: one cycle of latency
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);
    p_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_data == $past(in_data)));
  end

endmodule

bind wcoord_top wcoord_chk #(.IN_W(IN_W), .POW(POW), .DIR(DIR)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_data  (in_data),
  .in_flush (in_flush),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data)
);

// File: tb/wcoord_top_tb.sv
`timescale 1ns/1ps
module wcoord_top_tb;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  // split 16 -> 4
  logic        s_in_valid, s_in_ready, s_in_flush, s_out_valid, s_out_ready;
  logic [15:0] s_in_data;
  logic [3:0]  s_out_data;
  // pack 4 -> 16
  logic        p_in_valid, p_in_ready, p_in_flush, p_out_valid, p_out_ready;
  logic [3:0]  p_in_data;
  logic [15:0] p_out_data;
  // pass 16 -> 16
  logic        t_in_valid, t_in_ready, t_in_flush, t_out_valid, t_out_ready;
  logic [15:0] t_in_data;
  logic [15:0] t_out_data;
  // split 32 -> 4
  logic        w_in_valid, w_in_ready, w_in_flush, w_out_valid, w_out_ready;
  logic [31:0] w_in_data;
  logic [3:0]  w_out_data;

  wcoord_top #(.IN_W(16), .POW(2), .DIR(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(s_in_valid), .in_ready(s_in_ready),
    .in_data(s_in_data), .in_flush(s_in_flush), .out_valid(s_out_valid),
    .out_ready(s_out_ready), .out_data(s_out_data));

  wcoord_top #(.IN_W(4), .POW(2), .DIR(-1)) u_dut_pack (
    .clk(clk), .rst_n(rst_n), .in_valid(p_in_valid), .in_ready(p_in_ready),
    .in_data(p_in_data), .in_flush(p_in_flush), .out_valid(p_out_valid),
    .out_ready(p_out_ready), .out_data(p_out_data));

  wcoord_top #(.IN_W(16), .POW(0), .DIR(1)) u_dut_pass (
    .clk(clk), .rst_n(rst_n), .in_valid(t_in_valid), .in_ready(t_in_ready),
    .in_data(t_in_data), .in_flush(t_in_flush), .out_valid(t_out_valid),
    .out_ready(t_out_ready), .out_data(t_out_data));

  wcoord_top #(.IN_W(32), .POW(3), .DIR(1)) u_dut_wide (
    .clk(clk), .rst_n(rst_n), .in_valid(w_in_valid), .in_ready(w_in_ready),
    .in_data(w_in_data), .in_flush(w_in_flush), .out_valid(w_out_valid),
    .out_ready(w_out_ready), .out_data(w_out_data));

  localparam logic [15:0] VEC [0:7] = '{
    16'h1234, 16'hA5C3, 16'h0000, 16'hFFFF,
    16'h8001, 16'h7E18, 16'hBEEF, 16'h0F0F
  };

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called just after a falling edge; returns just after a falling edge.
  task automatic do_split(input logic [15:0] w);
    s_in_valid = 1'b1;
    s_in_data  = w;
    chk_eq("R4 ready before word", 32'(s_in_ready), 32'd1);
    @(negedge clk);
    s_in_valid = 1'b0;
    s_in_data  = ~w;                       // R10: ignored while valid is low
    for (int k = 0; k < 4; k++) begin
      chk_eq("R3 split beat valid", 32'(s_out_valid), 32'd1);
      chk_eq("R3 split slice order", 32'(s_out_data), 32'(w[4*k +: 4]));
      chk_eq("R4 ready low mid-word", 32'(s_in_ready), 32'd0);
      @(negedge clk);
    end
    chk_eq("R2 exactly four beats", 32'(s_out_valid), 32'd0);
    chk_eq("R4 ready returns", 32'(s_in_ready), 32'd1);
  endtask

  task automatic do_pack(input logic [15:0] w);
    for (int k = 0; k < 4; k++) begin
      p_in_valid = 1'b1;
      p_in_data  = w[4*k +: 4];
      chk_eq("R6 no early valid", 32'(p_out_valid), 32'd0);
      @(negedge clk);
    end
    p_in_valid = 1'b0;
    p_in_data  = 4'hA;                     // R10: ignored while valid is low
    chk_eq("R6 pack valid", 32'(p_out_valid), 32'd1);
    chk_eq("R6 pack order", 32'(p_out_data), 32'(w));
    chk_eq("R6 ready low while full", 32'(p_in_ready), 32'd0);
    @(negedge clk);
    chk_eq("R6 word drained", 32'(p_out_valid), 32'd0);
  endtask

  task automatic do_pass(input logic [15:0] w);
    t_in_valid = 1'b1;
    t_in_data  = w;
    @(negedge clk);
    t_in_valid = 1'b0;
    t_in_data  = ~w;                       // R10
    chk_eq("R1 pass valid", 32'(t_out_valid), 32'd1);
    chk_eq("R1 pass data", 32'(t_out_data), 32'(w));
    @(negedge clk);
    chk_eq("R10 pass idle", 32'(t_out_valid), 32'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    s_in_valid = 0; s_in_flush = 0; s_out_ready = 1; s_in_data = '0;
    p_in_valid = 0; p_in_flush = 0; p_out_ready = 1; p_in_data = '0;
    t_in_valid = 0; t_in_flush = 0; t_out_ready = 1; t_in_data = '0;
    w_in_valid = 0; w_in_flush = 0; w_out_ready = 1; w_in_data = '0;
    repeat (3) @(negedge clk);
    // R9 during reset
    chk_eq("R9 split valid in reset", 32'(s_out_valid), 32'd0);
    chk_eq("R9 pack valid in reset", 32'(p_out_valid), 32'd0);
    chk_eq("R9 pass valid in reset", 32'(t_out_valid), 32'd0);
    chk_eq("R9 split ready in reset", 32'(s_in_ready), 32'd1);
    chk_eq("R9 pack ready in reset", 32'(p_in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R9 split valid after release", 32'(s_out_valid), 32'd0);
    chk_eq("R9 pack ready after release", 32'(p_in_ready), 32'd1);
    chk_eq("R9 wide ready after release", 32'(w_in_ready), 32'd1);

    // Vector table walk, all three main modes
    for (int i = 0; i < 8; i++) begin
      do_split(VEC[i]);
      do_pack(VEC[i]);
      do_pass(VEC[i]);
    end

    // R2: much wider input, 32 -> 4 in eight beats
    chk_eq("R2 wide output width", 32'($bits(w_out_data)), 32'd4);
    w_in_valid = 1'b1;
    w_in_data  = 32'h89ABCDEF;
    @(negedge clk);
    w_in_valid = 1'b0;
    for (int k = 0; k < 8; k++) begin
      chk_eq("R2 wide beat valid", 32'(w_out_valid), 32'd1);
      chk_eq("R3 wide slice order", 32'(w_out_data), 32'(4'hF - k));
      @(negedge clk);
    end
    chk_eq("R2 wide beat count", 32'(w_out_valid), 32'd0);

    // R5: split stall on first beat and on an inner beat
    s_out_ready = 1'b0;
    s_in_valid  = 1'b1;
    s_in_data   = 16'hC0DE;
    @(negedge clk);
    s_in_valid = 1'b0;
    s_in_data  = 16'h1111;
    for (int k = 0; k < 3; k++) begin
      chk_eq("R5 split stall valid", 32'(s_out_valid), 32'd1);
      chk_eq("R5 split stall data", 32'(s_out_data), 32'hE);
      @(negedge clk);
    end
    s_out_ready = 1'b1;
    @(negedge clk);
    chk_eq("R3 split after stall", 32'(s_out_data), 32'hD);
    s_out_ready = 1'b0;
    @(negedge clk);
    chk_eq("R5 split inner stall", 32'(s_out_data), 32'hD);
    s_out_ready = 1'b1;
    @(negedge clk);
    chk_eq("R3 split slice 2", 32'(s_out_data), 32'h0);
    @(negedge clk);
    chk_eq("R3 split slice 3", 32'(s_out_data), 32'hC);
    @(negedge clk);
    chk_eq("R4 split done", 32'(s_out_valid), 32'd0);

    // R8: flush ignored when splitting
    s_in_flush = 1'b1;
    do_split(16'h5A69);
    s_in_flush = 1'b0;

    // R5 + R10: pack stall with a stray input offered while full
    p_out_ready = 1'b0;
    for (int k = 0; k < 4; k++) begin
      p_in_valid = 1'b1;
      p_in_data  = 4'(2 * (k + 1));
      @(negedge clk);
    end
    p_in_data = 4'hF;
    for (int k = 0; k < 3; k++) begin
      chk_eq("R5 pack stall valid", 32'(p_out_valid), 32'd1);
      chk_eq("R5 pack stall data", 32'(p_out_data), 32'h8642);
      chk_eq("R6 pack ready while stalled", 32'(p_in_ready), 32'd0);
      @(negedge clk);
    end
    p_in_valid  = 1'b0;
    p_out_ready = 1'b1;
    @(negedge clk);
    chk_eq("R5 pack released", 32'(p_out_valid), 32'd0);
    do_pack(16'h1357);

    // R7: flush after an all-ones word, without and with a sample
    do_pack(16'hFFFF);
    p_in_valid = 1'b1; p_in_data = 4'h3;
    @(negedge clk);
    p_in_data = 4'h9;
    @(negedge clk);
    p_in_valid = 1'b0;
    p_in_flush = 1'b1;
    chk_eq("R6 partial not valid", 32'(p_out_valid), 32'd0);
    @(negedge clk);
    p_in_flush = 1'b0;
    chk_eq("R7 flush valid", 32'(p_out_valid), 32'd1);
    chk_eq("R7 flush zero pad", 32'(p_out_data), 32'h0093);
    @(negedge clk);
    p_in_valid = 1'b1; p_in_data = 4'h5;
    @(negedge clk);
    p_in_data  = 4'h6;
    p_in_flush = 1'b1;
    @(negedge clk);
    p_in_valid = 1'b0;
    p_in_flush = 1'b0;
    chk_eq("R7 flush with sample valid", 32'(p_out_valid), 32'd1);
    chk_eq("R7 flush with sample data", 32'(p_out_data), 32'h0065);
    @(negedge clk);
    p_in_flush = 1'b1;
    @(negedge clk);
    p_in_flush = 1'b0;
    chk_eq("R7 empty flush no output", 32'(p_out_valid), 32'd0);
    @(negedge clk);
    chk_eq("R7 empty flush still idle", 32'(p_out_valid), 32'd0);
    do_pack(16'h4321);

    // R8: flush ignored in pass-through
    t_in_flush = 1'b1;
    @(negedge clk);
    chk_eq("R8 pass flush ignored", 32'(t_out_valid), 32'd0);
    @(negedge clk);
    t_in_flush = 1'b0;
    chk_eq("R8 pass flush still idle", 32'(t_out_valid), 32'd0);

    // R1: back-to-back pass-through, one word per cycle
    t_in_valid = 1'b1;
    for (int k = 0; k < 4; k++) begin
      t_in_data = 16'h1000 * 16'(k + 1) + 16'h00AB;
      @(negedge clk);
      chk_eq("R1 pass stream data", 32'(t_out_data), 32'(16'h1000 * 16'(k + 1) + 16'h00AB));
      chk_eq("R1 pass stream ready", 32'(t_in_ready), 32'd1);
    end
    t_in_valid = 1'b0;
    @(negedge clk);
    chk_eq("R1 pass stream drained", 32'(t_out_valid), 32'd0);

    // R5: pass-through stall
    t_out_ready = 1'b0;
    t_in_valid  = 1'b1;
    t_in_data   = 16'hAAAA;
    @(negedge clk);
    t_in_data = 16'hBBBB;
    chk_eq("R1 stall ready low", 32'(t_in_ready), 32'd0);
    @(negedge clk);
    chk_eq("R5 pass stall data", 32'(t_out_data), 32'hAAAA);
    t_out_ready = 1'b1;
    @(negedge clk);
    t_in_valid = 1'b0;
    chk_eq("R1 pass after stall", 32'(t_out_data), 32'hBBBB);
    @(negedge clk);
    chk_eq("R1 pass empty", 32'(t_out_valid), 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule